// File: doc/BRIEF.md
# Control Command Line Receiver

This block receives the serial control line that carries train commands to front-end electronics. The line is Manchester coded and sampled by the distributed synchronous clock at one sample per half-bit, so no clock recovery is needed. The half-bit phase is fixed by reset: the first sample after reset release is the first half of a bit. The block turns sample pairs into bits and hunts for a 4-bit command code. For the train-start command it also collects a payload and checks it before accepting it.

Three codes are recognised. The train-start code is followed by a 48-bit payload that holds a train number, a pattern identifier and a checksum. The train-end and front-end-reset codes carry no payload. The results come out as one-cycle strobes, a held train number and pattern identifier, and strobes for a checksum mismatch and for a line coding error.

The controller has four states. `S_HUNT` waits for the first decoded 1. `S_CODE` collects the other three code bits. `S_PAY` collects the payload. `S_CHECK` compares the checksum for one cycle. The named transitions are:
- hunt→code on a decoded 1.
- code→pay on the start code.
- code→hunt on the end code, the reset code or any other code.
- pay→check after the last payload bit.
- check→hunt always.
- code→hunt and pay→hunt on a bad pair.

Top module: `ctrl_cmd_rx`

## Requirements
- R1: While reset is asserted, and until the first command, all strobes are low and `train_id` and `pattern_id` are zero.
- R2: A bit is a pair of half-bit samples. High then low is 1 and low then high is 0. The first sample after reset is a first half. An idle line of encoded zeros produces no strobe.
- R3: In hunt, the first decoded 1 is the most significant bit of a 4-bit command code, and the next three decoded bits complete the code, MSB first.
- R4: Code 1010 gives a single-cycle `stop_stb` right after the code. It has no payload.
- R5: Code 1001 gives a single-cycle `reset_stb` right after the code. It has no payload.
- R6: Code 1100 is followed by 48 bits sent MSB first: a 32-bit train number, then an 8-bit pattern identifier, then an 8-bit checksum.
- R7: If the XOR of the four train-number bytes and the pattern byte equals the checksum, `start_stb` pulses for one cycle. `train_id` and `pattern_id` take the new values in that same cycle.
- R8: On a checksum mismatch, `csum_err_stb` pulses for one cycle and `train_id` and `pattern_id` keep their previous values.
- R9: Code 1111, and any other code not listed in R4 to R6, is discarded with no strobe, and hunting resumes.
- R10: A pair of equal halves (00 or 11) pulses `code_err_stb`, aborts any frame in progress and returns the receiver to hunt.
- R11: At most one of `start_stb`, `stop_stb`, `reset_stb` and `csum_err_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one sample per half-bit |
| rst_n | input | 1 | Active-low synchronous reset, also fixes half-bit phase |
| line_in | input | 1 | Manchester-coded control line |
| start_stb | output | 1 | Accepted train-start command |
| stop_stb | output | 1 | Train-end command |
| reset_stb | output | 1 | Front-end reset command |
| csum_err_stb | output | 1 | Train-start rejected by checksum |
| code_err_stb | output | 1 | Invalid Manchester pair seen |
| train_id | output | 32 | Train number of the last accepted start |
| pattern_id | output | 8 | Pattern identifier of the last accepted start |

## Verification
Directed frames of each of the three commands are compared against idle stretches to show that only real codes produce strobes. A start frame with one flipped checksum bit shows that a mismatch rejects the frame and leaves the held fields alone. Unlisted codes such as 1111 and 1101 show that a leading 1 alone is not enough. A bad pair injected mid-payload shows that the frame is aborted, and a following end command shows that hunting recovers. A seeded random mix of all frame kinds, with random identifiers and random checksum corruption, checks strobe counts and captured fields against values the bench computes itself.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_START = 4'b1100;
    localparam logic [CODE_W-1:0] CODE_STOP  = 4'b1010;
    localparam logic [CODE_W-1:0] CODE_RESET = 4'b1001;

    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_CODE  = 2'd1,
        S_PAY   = 2'd2,
        S_CHECK = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ccr_manchester_dec.sv
module ccr_manchester_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_vld,
    output logic bit_val,
    output logic bit_bad
);
    logic phase;
    logic first_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= 1'b0;
            first_half <= 1'b0;
            bit_vld    <= 1'b0;
            bit_val    <= 1'b0;
            bit_bad    <= 1'b0;
        end else begin
            phase   <= ~phase;
            bit_vld <= 1'b0;
            bit_bad <= 1'b0;
            if (!phase) begin
                first_half <= line_in;
            end else if (first_half != line_in) begin
                bit_vld <= 1'b1;
                bit_val <= first_half;
            end else begin
                bit_bad <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccr_csum.sv
module ccr_csum #(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0]          data,
    input  logic [ccr_pkg::BYTE_W-1:0] csum,
    output logic                       ok
);
    localparam int BW     = ccr_pkg::BYTE_W;
    localparam int NBYTES = DATA_W / BW;

    logic [BW-1:0] acc [NBYTES+1];

    assign acc[0] = '0;
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign acc[i+1] = acc[i] ^ data[i*BW +: BW];
    end

    assign ok = (acc[NBYTES] == csum);
endmodule

// File: rtl/ctrl_cmd_rx.sv
module ctrl_cmd_rx #(
    parameter int ID_W  = 32,
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             start_stb,
    output logic             stop_stb,
    output logic             reset_stb,
    output logic             csum_err_stb,
    output logic             code_err_stb,
    output logic [ID_W-1:0]  train_id,
    output logic [PAT_W-1:0] pattern_id
);
    import ccr_pkg::*;

    localparam int DATA_W = ID_W + PAT_W;
    localparam int PAY_W  = DATA_W + BYTE_W;
    localparam int CNT_W  = $clog2(PAY_W);
    localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(PAY_W - 1);

    logic bit_vld, bit_val, bit_bad;
    logic csum_ok;

    rx_state_e           state, nxt;
    logic [CNT_W-1:0]    cnt;
    logic [PAY_W-1:0]    shreg;
    logic [CODE_W-1:0]   code_next;

    ccr_manchester_dec u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_bad (bit_bad)
    );

    ccr_csum #(.DATA_W(DATA_W)) u_csum (
        .data (shreg[PAY_W-1 -: DATA_W]),
        .csum (shreg[BYTE_W-1:0]),
        .ok   (csum_ok)
    );

    assign code_next = {shreg[CODE_W-2:0], bit_val};

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_HUNT:  if (bit_vld && bit_val) nxt = S_CODE;
            S_CODE: begin
                if (bit_bad) nxt = S_HUNT;
                else if (bit_vld && cnt == CODE_LAST)
                    nxt = (code_next == CODE_START) ? S_PAY : S_HUNT;
            end
            S_PAY: begin
                if (bit_bad) nxt = S_HUNT;
                else if (bit_vld && cnt == PAY_LAST) nxt = S_CHECK;
            end
            S_CHECK: nxt = S_HUNT;
        endcase
    end

    // state register with bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HUNT;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_HUNT: begin
                    cnt   <= CNT_W'(1);
                    shreg <= {{(PAY_W-1){1'b0}}, 1'b1};
                end
                S_CODE: if (bit_vld) begin
                    shreg <= {shreg[PAY_W-2:0], bit_val};
                    cnt   <= (cnt == CODE_LAST) ? '0 : cnt + 1'b1;
                end
                S_PAY: if (bit_vld) begin
                    shreg <= {shreg[PAY_W-2:0], bit_val};
                    cnt   <= cnt + 1'b1;
                end
                S_CHECK: cnt <= '0;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_stb    <= 1'b0;
            stop_stb     <= 1'b0;
            reset_stb    <= 1'b0;
            csum_err_stb <= 1'b0;
            code_err_stb <= 1'b0;
            train_id     <= '0;
            pattern_id   <= '0;
        end else begin
            start_stb    <= 1'b0;
            stop_stb     <= 1'b0;
            reset_stb    <= 1'b0;
            csum_err_stb <= 1'b0;
            code_err_stb <= bit_bad;
            unique case (state)
                S_CODE: if (bit_vld && cnt == CODE_LAST) begin
                    stop_stb  <= (code_next == CODE_STOP);
                    reset_stb <= (code_next == CODE_RESET);
                end
                S_CHECK: begin
                    if (csum_ok) begin
                        start_stb  <= 1'b1;
                        train_id   <= shreg[PAY_W-1 -: ID_W];
                        pattern_id <= shreg[BYTE_W +: PAT_W];
                    end else begin
                        csum_err_stb <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
    parameter int ID_W  = 32,
    parameter int PAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_stb,
    input logic             stop_stb,
    input logic             reset_stb,
    input logic             csum_err_stb,
    input logic             code_err_stb,
    input logic [ID_W-1:0]  train_id,
    input logic [PAT_W-1:0] pattern_id,
    input logic             bit_vld,
    input logic             bit_bad,
    input logic             in_hunt
);
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stb, stop_stb, reset_stb, csum_err_stb}));

    a_r8_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_stb |-> ($stable(train_id) && $stable(pattern_id)));

    a_r10_bad_pair_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        bit_bad |=> in_hunt);

    a_r10_code_err_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_stb |-> $past(bit_bad));

    a_r4_stop_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb || reset_stb) |-> $past(bit_vld));

    a_r2_one_bit_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld || bit_bad) |=> !(bit_vld || bit_bad));
endmodule

bind ctrl_cmd_rx ccr_checker #(.ID_W(ID_W), .PAT_W(PAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_stb    (start_stb),
    .stop_stb     (stop_stb),
    .reset_stb    (reset_stb),
    .csum_err_stb (csum_err_stb),
    .code_err_stb (code_err_stb),
    .train_id     (train_id),
    .pattern_id   (pattern_id),
    .bit_vld      (bit_vld),
    .bit_bad      (bit_bad),
    .in_hunt      (state == ccr_pkg::S_HUNT)
);

// File: tb/ctrl_cmd_rx_bench.sv
module ctrl_cmd_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic        start_stb, stop_stb, reset_stb, csum_err_stb, code_err_stb;
    logic [31:0] train_id;
    logic [7:0]  pattern_id;

    int checks = 0, failures = 0;
    int n_start = 0, n_stop = 0, n_reset = 0, n_cerr = 0, n_code = 0, n_multi = 0;
    logic [31:0] cap_train = '0;
    logic [7:0]  cap_pat = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_cmd_rx u_ctrl_cmd_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .start_stb(start_stb), .stop_stb(stop_stb), .reset_stb(reset_stb),
        .csum_err_stb(csum_err_stb), .code_err_stb(code_err_stb),
        .train_id(train_id), .pattern_id(pattern_id)
    );

    always @(negedge clk) if (rst_n) begin
        if (start_stb) begin n_start++; cap_train = train_id; cap_pat = pattern_id; end
        if (stop_stb) n_stop++;
        if (reset_stb) n_reset++;
        if (csum_err_stb) n_cerr++;
        if (code_err_stb) n_code++;
        if ($countones({start_stb, stop_stb, reset_stb, csum_err_stb}) > 1) n_multi++;
    end

    function automatic logic [7:0] xsum(input logic [31:0] id, input logic [7:0] pat);
        return id[31:24] ^ id[23:16] ^ id[15:8] ^ id[7:0] ^ pat;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        line_in = b;
        @(negedge clk);
        line_in = ~b;
        @(negedge clk);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_code(input logic [3:0] c);
        for (int i = 3; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_start(input logic [31:0] id, input logic [7:0] pat, input logic [7:0] cs);
        logic [47:0] p;
        p = {id, pat, cs};
        send_code(4'b1100);
        for (int i = 47; i >= 0; i--) send_bit(p[i]);
    endtask

    task automatic expect_counts(input string req, input int es, input int et,
                                 input int er, input int ec, input int eb);
        chk(n_start == es, req, "start count", n_start, es);
        chk(n_stop == et, req, "stop count", n_stop, et);
        chk(n_reset == er, req, "reset count", n_reset, er);
        chk(n_cerr == ec, req, "csum err count", n_cerr, ec);
        chk(n_code == eb, req, "code err count", n_code, eb);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int es, et, er, ec, eb;
        logic [31:0] exp_train;
        logic [7:0]  exp_pat;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        // R1 reset values
        chk(!(start_stb | stop_stb | reset_stb | csum_err_stb | code_err_stb), "R1",
            "strobes in reset", {start_stb, stop_stb, reset_stb, csum_err_stb, code_err_stb}, 0);
        chk(train_id == 0 && pattern_id == 0, "R1", "ids in reset", {train_id, pattern_id}, 0);
        rst_n = 1'b1;

        // R2 idle gives nothing
        send_idle(20);
        expect_counts("R2", 0, 0, 0, 0, 0);
        chk(train_id == 0, "R1", "train after idle", train_id, 0);

        // R4 stop
        send_code(4'b1010); send_idle(6);
        expect_counts("R4", 0, 1, 0, 0, 0);
        // R5 reset
        send_code(4'b1001); send_idle(6);
        expect_counts("R5", 0, 1, 1, 0, 0);

        // R6 R7 valid start
        send_start(32'hDEADBEEF, 8'h5A, xsum(32'hDEADBEEF, 8'h5A)); send_idle(6);
        expect_counts("R7", 1, 1, 1, 0, 0);
        chk(cap_train == 32'hDEADBEEF, "R6", "train id", cap_train, 32'hDEADBEEF);
        chk(cap_pat == 8'h5A, "R6", "pattern id", cap_pat, 8'h5A);

        // R8 bad checksum
        send_start(32'h01234567, 8'hC3, xsum(32'h01234567, 8'hC3) ^ 8'h10); send_idle(6);
        expect_counts("R8", 1, 1, 1, 1, 0);
        chk(train_id == 32'hDEADBEEF, "R8", "train held", train_id, 32'hDEADBEEF);
        chk(pattern_id == 8'h5A, "R8", "pattern held", pattern_id, 8'h5A);

        // R9 reserved and unlisted codes
        send_code(4'b1111); send_idle(6);
        send_code(4'b1101); send_idle(6);
        send_code(4'b1000); send_idle(6);
        expect_counts("R9", 1, 1, 1, 1, 0);

        // R10 bad pair mid-payload, then recovery
        send_code(4'b1100);
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        line_in = 1'b1; @(negedge clk); line_in = 1'b1; @(negedge clk);
        send_idle(30);
        expect_counts("R10", 1, 1, 1, 1, 1);
        chk(train_id == 32'hDEADBEEF, "R10", "train held after abort", train_id, 32'hDEADBEEF);
        send_code(4'b1010); send_idle(6);
        expect_counts("R3", 1, 2, 1, 1, 1);

        // seeded random mix
        es = n_start; et = n_stop; er = n_reset; ec = n_cerr; eb = n_code;
        exp_train = cap_train; exp_pat = cap_pat;
        for (int k = 0; k < 60; k++) begin
            int kind;
            logic [31:0] id;
            logic [7:0]  pat;
            logic [3:0]  junk;
            kind = $urandom % 5;
            id = $urandom; pat = 8'($urandom);
            case (kind)
                0: begin send_code(4'b1010); et++; end
                1: begin send_code(4'b1001); er++; end
                2: begin send_start(id, pat, xsum(id, pat)); es++; exp_train = id; exp_pat = pat; end
                3: begin send_start(id, pat, xsum(id, pat) ^ (8'd1 << ($urandom % 8))); ec++; end
                default: begin
                    junk = {1'b1, 3'($urandom)};
                    if (junk == 4'b1100 || junk == 4'b1010 || junk == 4'b1001) junk = 4'b1111;
                    send_code(junk);
                end
            endcase
            send_idle(2 + ($urandom % 4));
            if (kind == 2) begin
                chk(cap_train == exp_train, "R7", "random train id", cap_train, exp_train);
                chk(cap_pat == exp_pat, "R7", "random pattern id", cap_pat, exp_pat);
            end
        end
        expect_counts("R6", es, et, er, ec, eb);
        chk(train_id == exp_train, "R8", "final train id", train_id, exp_train);
        chk(n_multi == 0, "R11", "overlapping strobes", n_multi, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule